// File: doc/BRIEF.md
# Register Rename Status Table

This block sits at the issue stage of an out-of-order core. It holds the architectural register values and, for each register, a status entry. The entry is either empty, or it holds the tag of the station that will produce the newest value of that register. An issuing instruction looks up both of its sources in the same cycle. Each lookup returns one of two things: a usable value with a zero tag, or the nonzero tag of the pending producer. The source then waits for that tag on the result bus instead of stalling.

In the same cycle the issuing instruction binds its destination register to its own station tag. That binding replaces whatever tag was there before. The block snoops the single result bus. A result is written into a register only when its tag is the one that register currently names. Results from producers that a later writer has superseded never reach the register file. This removes write-after-write and write-after-read hazards without stalls. The stations and execution units are outside this block.

Top module: `rrt_rename_table`

## Requirements
- R1: After a synchronous active-low reset, every status entry is empty and every register value is zero. A lookup of any register then returns data 0 and tag 0.
- R2: A lookup of a register whose entry is empty (tag 0) returns the stored register value on the data output and 0 on the tag output, in the same cycle.
- R3: A lookup of a register whose entry holds a nonzero tag, with no matching broadcast in that cycle, returns that tag and data 0.
- R4: When `dst_we` is high at a clock edge, the entry of register `dst_idx` holds `dst_tag` from the next cycle on. This replaces any older tag unconditionally. `dst_tag` is never 0.
- R5: When `bc_valid` is high and `bc_tag` equals a register's current entry, the next edge writes `bc_data` into that register and clears its entry to 0.
- R6: A broadcast whose tag matches no current entry, for example a producer superseded by a later writer, leaves every register value and every entry unchanged.
- R7: When an issue reads and writes the same register in one cycle, the lookup returns that register's state from before the destination update.
- R8: When a matching broadcast and an issue target the same register in the same cycle, the entry holds the new issue tag after the edge.
- R9: When a lookup hits a pending entry whose tag is on the bus in that cycle, the lookup returns `bc_data` with tag 0, never the pending tag.
- R10: With `dst_we` low and `bc_valid` low, no entry and no register value changes, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_a_idx | input | IDX_W | Register index for lookup port A |
| src_b_idx | input | IDX_W | Register index for lookup port B |
| src_a_data | output | DATA_W | Value for port A (0 while pending) |
| src_a_tag | output | TAG_W | Producer tag for port A (0 when the value is usable) |
| src_b_data | output | DATA_W | Value for port B (0 while pending) |
| src_b_tag | output | TAG_W | Producer tag for port B (0 when the value is usable) |
| dst_we | input | 1 | Bind the destination register to a new producer |
| dst_idx | input | IDX_W | Destination register index |
| dst_tag | input | TAG_W | Tag of the issuing station (nonzero) |
| bc_valid | input | 1 | Result bus carries a result this cycle |
| bc_tag | input | TAG_W | Tag of the producing station |
| bc_data | input | DATA_W | Result value |

## Verification
The lookup outputs are combinational, so R2, R3, R7 and R9 are due in the same cycle the index and bus inputs are driven. The bench drives inputs just after a falling edge and samples one nanosecond later, before the next rising edge commits anything. R4, R5, R6, R8 and R10 land one rising edge after the stimulus. The bench checks them with lookups in the following low phase, after the stimulus inputs have been withdrawn, so a same-cycle forward cannot hide a state that failed to update.

// File: rtl/rrt_pkg.sv
// Package: shared definitions for the register rename status table.
// Assumes tag value zero is reserved to mean "no pending producer".
package rrt_pkg;

    // Where a lookup result comes from.
    typedef enum logic [1:0] {
        SRC_FILE    = 2'd0,   // entry empty: register file value is current
        SRC_BUS     = 2'd1,   // entry pending but its producer is on the bus now
        SRC_PENDING = 2'd2    // entry pending, wait for the tag
    } lookup_src_e;

    localparam int unsigned NO_TAG = 0;

endpackage

// File: rtl/rrt_status_table.sv
// Module: rrt_status_table
// Keeps one tag entry per architectural register. An issue write binds
// the destination to a new tag. A matching broadcast clears the entry.
// When both hit one entry in the same cycle, the issue wins.
// Assumes at most one live entry holds any given nonzero tag.
module rrt_status_table #(
    parameter int unsigned NUM_REGS = 16,
    parameter int unsigned TAG_W    = 4,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      dst_we,
    input  logic [IDX_W-1:0]          dst_idx,
    input  logic [TAG_W-1:0]          dst_tag,
    input  logic                      bc_valid,
    input  logic [TAG_W-1:0]          bc_tag,
    output logic [NUM_REGS*TAG_W-1:0] tag_flat,
    output logic [NUM_REGS-1:0]       hit_vec
);
    logic [TAG_W-1:0] tag_q [NUM_REGS];
    logic             bus_live;

    // Purpose: a broadcast with the reserved zero tag can never match.
    assign bus_live = bc_valid && (bc_tag != TAG_W'(rrt_pkg::NO_TAG));

    genvar g;
    generate
        for (g = 0; g < NUM_REGS; g++) begin : g_entry
            // Purpose: flag the entry whose producer is broadcasting now.
            assign hit_vec[g] = bus_live && (tag_q[g] == bc_tag);
            // Purpose: expose entry g on the flattened tag bus.
            assign tag_flat[g*TAG_W +: TAG_W] = tag_q[g];
        end
    endgenerate

    // Purpose: update entries; a new issue binding outranks a clear.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_REGS; i++) begin
            if (!rst_n) begin
                tag_q[i] <= '0;
            end else if (dst_we && (dst_idx == IDX_W'(i))) begin
                tag_q[i] <= dst_tag;
            end else if (hit_vec[i]) begin
                tag_q[i] <= '0;
            end
        end
    end

    // R4 and R8: an issue binding is always visible after the edge.
    p_issue_binds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dst_we |=> (tag_q[$past(dst_idx)] == $past(dst_tag)));

    // R6: the tags held in entries are unique, so at most one entry matches.
    p_single_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

endmodule

// File: rtl/rrt_value_file.sv
// Module: rrt_value_file
// Architectural register storage. A register is written only when the
// status table reports that its current producer is on the result bus.
// Assumes hit_vec has at most one bit set.
module rrt_value_file #(
    parameter int unsigned NUM_REGS = 16,
    parameter int unsigned DATA_W   = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_REGS-1:0]        hit_vec,
    input  logic [DATA_W-1:0]          bc_data,
    output logic [NUM_REGS*DATA_W-1:0] val_flat
);
    logic [DATA_W-1:0] val_q [NUM_REGS];

    // Purpose: write the broadcast value only into the matching register.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_REGS; i++) begin
            if (!rst_n) begin
                val_q[i] <= '0;
            end else if (hit_vec[i]) begin
                val_q[i] <= bc_data;
            end
        end
    end

    genvar g;
    generate
        for (g = 0; g < NUM_REGS; g++) begin : g_reg
            // Purpose: expose register g on the flattened value bus.
            assign val_flat[g*DATA_W +: DATA_W] = val_q[g];

            // R5: a matching broadcast lands in the register.
            p_match_writes_r5: assert property (@(posedge clk) disable iff (!rst_n)
                hit_vec[g] |=> (val_q[g] == $past(bc_data)));

            // R6: with no match, the register keeps its value.
            p_stale_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
                !hit_vec[g] |=> $stable(val_q[g]));
        end
    endgenerate

endmodule

// File: rtl/rrt_lookup_port.sv
// Module: rrt_lookup_port
// One combinational source lookup. It selects the register value, a
// same-cycle bus value, or the pending producer tag. It reads the state
// from before this cycle's update, so a same-cycle issue never affects it.
module rrt_lookup_port #(
    parameter int unsigned NUM_REGS = 16,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned TAG_W    = 4,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
    input  logic [IDX_W-1:0]           idx,
    input  logic [NUM_REGS*TAG_W-1:0]  tag_flat,
    input  logic [NUM_REGS*DATA_W-1:0] val_flat,
    input  logic                       bc_valid,
    input  logic [TAG_W-1:0]           bc_tag,
    input  logic [DATA_W-1:0]          bc_data,
    output logic [DATA_W-1:0]          out_data,
    output logic [TAG_W-1:0]           out_tag
);
    import rrt_pkg::*;

    logic [TAG_W-1:0]  ent_tag;
    logic [DATA_W-1:0] ent_val;
    lookup_src_e       src_sel;

    // Purpose: pick the addressed entry and register.
    always_comb begin
        ent_tag = '0;
        ent_val = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (idx == IDX_W'(i)) begin
                ent_tag = tag_flat[i*TAG_W +: TAG_W];
                ent_val = val_flat[i*DATA_W +: DATA_W];
            end
        end
    end

    // Purpose: classify where the result comes from.
    always_comb begin
        if (ent_tag == TAG_W'(NO_TAG))                 src_sel = SRC_FILE;
        else if (bc_valid && (bc_tag == ent_tag))      src_sel = SRC_BUS;
        else                                           src_sel = SRC_PENDING;
    end

    // Purpose: drive the value and tag for the chosen source.
    always_comb begin
        unique case (src_sel)
            SRC_FILE:    begin out_data = ent_val; out_tag = '0;      end
            SRC_BUS:     begin out_data = bc_data; out_tag = '0;      end
            SRC_PENDING: begin out_data = '0;      out_tag = ent_tag; end
            default:     begin out_data = '0;      out_tag = '0;      end
        endcase
    end

endmodule

// File: rtl/rrt_rename_table.sv
// Module: rrt_rename_table (top)
// Register status table with renaming. It provides two source lookups, one
// destination binding and one result-bus snoop per cycle. Lookups are
// combinational. State updates take effect at the next rising edge.
// Assumes: dst_tag is nonzero, and a station tag is live for at most
// one register at a time.
module rrt_rename_table #(
    parameter int unsigned NUM_REGS = 16,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned TAG_W    = 4,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  src_a_idx,
    input  logic [IDX_W-1:0]  src_b_idx,
    output logic [DATA_W-1:0] src_a_data,
    output logic [TAG_W-1:0]  src_a_tag,
    output logic [DATA_W-1:0] src_b_data,
    output logic [TAG_W-1:0]  src_b_tag,
    input  logic              dst_we,
    input  logic [IDX_W-1:0]  dst_idx,
    input  logic [TAG_W-1:0]  dst_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_data
);
    localparam int unsigned PORTS = 2;

    logic [NUM_REGS*TAG_W-1:0]  tag_flat;
    logic [NUM_REGS*DATA_W-1:0] val_flat;
    logic [NUM_REGS-1:0]        hit_vec;
    logic [IDX_W-1:0]           port_idx  [PORTS];
    logic [DATA_W-1:0]          port_data [PORTS];
    logic [TAG_W-1:0]           port_tag  [PORTS];

    rrt_status_table #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W)) status_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .dst_we   (dst_we),
        .dst_idx  (dst_idx),
        .dst_tag  (dst_tag),
        .bc_valid (bc_valid),
        .bc_tag   (bc_tag),
        .tag_flat (tag_flat),
        .hit_vec  (hit_vec)
    );

    rrt_value_file #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) values_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_vec  (hit_vec),
        .bc_data  (bc_data),
        .val_flat (val_flat)
    );

    // Purpose: route the port indexes into the lookup array.
    assign port_idx[0] = src_a_idx;
    assign port_idx[1] = src_b_idx;

    genvar p;
    generate
        for (p = 0; p < PORTS; p++) begin : g_port
            rrt_lookup_port #(
                .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)
            ) lookup_i (
                .idx      (port_idx[p]),
                .tag_flat (tag_flat),
                .val_flat (val_flat),
                .bc_valid (bc_valid),
                .bc_tag   (bc_tag),
                .bc_data  (bc_data),
                .out_data (port_data[p]),
                .out_tag  (port_tag[p])
            );
        end
    endgenerate

    // Purpose: drive the named output ports.
    assign src_a_data = port_data[0];
    assign src_a_tag  = port_tag[0];
    assign src_b_data = port_data[1];
    assign src_b_tag  = port_tag[1];

    // R4: an issuing station never uses the reserved empty tag.
    p_dst_tag_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dst_we |-> (dst_tag != '0));

    // R9: a lookup never hands out a tag that is being paid this cycle.
    p_no_stale_tag_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (src_a_tag != '0) |-> !(bc_valid && (bc_tag == src_a_tag)));
    p_no_stale_tag_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (src_b_tag != '0) |-> !(bc_valid && (bc_tag == src_b_tag)));

endmodule

// File: tb/rrt_rename_table_tb.sv
// Directed bench for rrt_rename_table. Inputs change just after a falling
// edge; combinational lookups are sampled 1 ns later; state is committed
// at the next rising edge.
module rrt_rename_table_tb_top;
    localparam int unsigned NUM_REGS = 16;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned TAG_W    = 4;
    localparam int unsigned IDX_W    = $clog2(NUM_REGS);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [IDX_W-1:0]  src_a_idx = '0, src_b_idx = '0, dst_idx = '0;
    logic [DATA_W-1:0] src_a_data, src_b_data, bc_data = '0;
    logic [TAG_W-1:0]  src_a_tag, src_b_tag, dst_tag = '0, bc_tag = '0;
    logic              dst_we = 1'b0, bc_valid = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    rrt_rename_table #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
        .src_a_data(src_a_data), .src_a_tag(src_a_tag),
        .src_b_data(src_b_data), .src_b_tag(src_b_tag),
        .dst_we(dst_we), .dst_idx(dst_idx), .dst_tag(dst_tag),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    // Commit at the rising edge, return to the low phase and clear strobes.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        dst_we = 1'b0;
        bc_valid = 1'b0;
    endtask

    task automatic issue(input int r, input int t);
        dst_we = 1'b1; dst_idx = IDX_W'(r); dst_tag = TAG_W'(t);
    endtask

    task automatic bcast(input int t, input logic [31:0] v);
        bc_valid = 1'b1; bc_tag = TAG_W'(t); bc_data = v;
    endtask

    task automatic look_a(input int r);
        src_a_idx = IDX_W'(r); #1;
    endtask

    // R1: everything empty and zero after reset.
    task automatic t_reset();
        for (int r = 0; r < NUM_REGS; r++) begin
            src_a_idx = IDX_W'(r); src_b_idx = IDX_W'(NUM_REGS - 1 - r); #1;
            chk("R1", "reset tag A", 32'(src_a_tag), 0);
            chk("R1", "reset data A", src_a_data, 0);
            chk("R1", "reset tag B", 32'(src_b_tag), 0);
        end
    endtask

    // R4, R3, R5, R2: bind, see pending, pay, read value back.
    task automatic t_bind_and_pay();
        issue(2, 5); tick();
        look_a(2);
        chk("R4", "bound tag", 32'(src_a_tag), 5);
        chk("R3", "pending data", src_a_data, 0);
        bcast(5, 32'hCAFE_0002); tick();
        look_a(2);
        chk("R5", "cleared tag", 32'(src_a_tag), 0);
        chk("R2", "file value", src_a_data, 32'hCAFE_0002);
        src_b_idx = IDX_W'(2); #1;
        chk("R2", "port B value", src_b_data, 32'hCAFE_0002);
    endtask

    // R6: write-after-write, the older producer's result is dropped.
    task automatic t_superseded();
        issue(1, 1); tick();          // first writer of r1
        issue(1, 2); tick();          // later writer replaces it
        look_a(1);
        chk("R4", "newest tag wins", 32'(src_a_tag), 2);
        bcast(1, 32'd42); #1;
        chk("R3", "stale bus does not forward", 32'(src_a_tag), 2);
        tick();
        look_a(1);
        chk("R6", "entry kept after stale bcast", 32'(src_a_tag), 2);
        bcast(2, 32'd7); tick();
        look_a(1);
        chk("R6", "only newest value lands", src_a_data, 7);
        bcast(2, 32'd99); tick();     // tag 2 no longer live anywhere
        look_a(1);
        chk("R6", "late dup bcast ignored", src_a_data, 7);
        look_a(2);
        chk("R6", "other reg untouched", src_a_data, 32'hCAFE_0002);
    endtask

    // R7: same register as source and destination.
    task automatic t_src_is_dst();
        issue(2, 9); src_a_idx = IDX_W'(2); #1;
        chk("R7", "old tag seen", 32'(src_a_tag), 0);
        chk("R7", "old value seen", src_a_data, 32'hCAFE_0002);
        tick();
        look_a(2);
        chk("R7", "tag after edge", 32'(src_a_tag), 9);
        bcast(9, 32'h0000_0909); tick();
    endtask

    // R8: clear and new binding collide on one entry.
    task automatic t_clear_vs_issue();
        issue(5, 3); tick();
        bcast(3, 32'h33); issue(5, 4); tick();
        look_a(5);
        chk("R8", "new tag survives", 32'(src_a_tag), 4);
        bcast(4, 32'h44); tick();
        look_a(5);
        chk("R8", "final value", src_a_data, 32'h44);
    endtask

    // R9: same-cycle forward on both ports.
    task automatic t_forward();
        issue(6, 6); tick();
        bcast(6, 32'h55); src_a_idx = IDX_W'(6); src_b_idx = IDX_W'(6); #1;
        chk("R9", "fwd tag A", 32'(src_a_tag), 0);
        chk("R9", "fwd data A", src_a_data, 32'h55);
        chk("R9", "fwd data B", src_b_data, 32'h55);
        tick();
        look_a(6);
        chk("R5", "value after fwd", src_a_data, 32'h55);
    endtask

    // R10: idle strobes, busy payloads.
    task automatic t_idle();
        issue(7, 8); tick();
        dst_we = 1'b0; dst_idx = IDX_W'(6); dst_tag = TAG_W'(11);
        bc_valid = 1'b0; bc_tag = TAG_W'(8); bc_data = 32'hDEAD;
        @(posedge clk); @(negedge clk);
        look_a(7);
        chk("R10", "pending kept", 32'(src_a_tag), 8);
        look_a(6);
        chk("R10", "other reg value", src_a_data, 32'h55);
        chk("R10", "other reg tag", 32'(src_a_tag), 0);
        bcast(8, 32'h88); tick();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_bind_and_pay();
        t_superseded();
        t_src_is_dst();
        t_clear_vs_issue();
        t_forward();
        t_idle();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule